// File: doc/BRIEF.md
# Block Guard Time ETU Monitor

This block watches the spacing between characters on a smart card I/O line, measured in elementary time units (ETUs). An upstream receiver supplies a one-cycle pulse for every detected start bit, and a divider supplies a one-cycle tick for every ETU. On each start bit the monitor clears its count and its status flag. It then counts ETU ticks until the guard time of the active protocol has elapsed. At that point it raises a status flag and holds the count.

The guard time is 16 ETUs under protocol T=0 and 22 ETUs under protocol T=1. The protocol input is sampled only on a start bit, so a change of selection between start bits does not disturb a measurement already under way. Software or a protocol engine reads the flag to confirm that the block guard time was respected before it transmits. The running count is also brought out for observation.

Top module: `bgt_etu_monitor`

## Requirements
- R1: While reset is active and in the first cycle after it, `etu_count` is 0 and `guard_met` is 0.
- R2: An `etu_tick` with no `start_pulse` in the same cycle adds one to `etu_count` on the next clock edge, provided the count is below the terminal value.
- R3: A `start_pulse` sets `etu_count` to 0 and `guard_met` to 0 on the next clock edge, whatever their previous values.
- R4: With `proto_t1` = 0 sampled at the last start bit, the terminal value is 16. `guard_met` becomes 1 on the edge at which `etu_count` becomes 16.
- R5: With `proto_t1` = 1 sampled at the last start bit, the terminal value is 22. `guard_met` becomes 1 on the edge at which `etu_count` becomes 22.
- R6: Once at the terminal value, `etu_count` stays there and `guard_met` stays 1 through any number of further ticks, until the next `start_pulse`.
- R7: When `start_pulse` and `etu_tick` are both high in one cycle, the tick has no effect: `etu_count` becomes 0, not 1.
- R8: `proto_t1` is sampled only in a cycle with `start_pulse` high. A change of it at any other time leaves the terminal value of the current measurement unchanged.
- R9: From reset until the first start bit, the terminal value is 16 (T=0), whatever the value of `proto_t1`.
- R10: `guard_met` is 1 exactly when `etu_count` equals the active terminal value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| etu_tick | input | 1 | One-cycle pulse per elapsed ETU |
| start_pulse | input | 1 | One-cycle pulse per detected start bit |
| proto_t1 | input | 1 | Protocol select: 0 for T=0, 1 for T=1 |
| guard_met | output | 1 | Block guard time has elapsed since the last start bit |
| etu_count | output | CNT_W (5) | ETUs counted since the last start bit, saturating |

## Verification
The hardest case to reach is a change of the protocol select in the middle of a measurement. It has to come after the start bit and before the terminal count, and it only shows up as a wrong terminal value 16 or 22 ticks later. The stimulus starts under T=1, flips the select to T=0 a few ticks in, and continues past 22 ticks. It also does the reverse, starting under T=0 and flipping to T=1. A behavioural model that latches the protocol only on start bits is compared with the outputs every cycle. A long random phase then mixes ticks, start bits, coincident start-and-tick cycles and protocol toggles, with start bits rare enough that both terminal values are reached often.

// File: rtl/bgt_pkg.sv
package bgt_pkg;
   typedef enum logic {
      PROTO_T0 = 1'b0,
      PROTO_T1 = 1'b1
   } bgt_proto_e;

   function automatic int unsigned bgt_term_for(input bgt_proto_e p,
                                                input int unsigned t0,
                                                input int unsigned t1);
      return (p == PROTO_T1) ? t1 : t0;
   endfunction
endpackage

// File: rtl/bgt_term_select.sv
// Holds the terminal count of the measurement in progress; the protocol is
// captured only when a start bit arrives.
module bgt_term_select
   import bgt_pkg::*;
#(
   parameter int unsigned CNT_W       = 5,
   parameter int unsigned TERM_T0     = 16,
   parameter int unsigned TERM_T1     = 22,
   parameter bit          RESET_PROTO = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             proto_i,
   output logic [CNT_W-1:0] term_o
);
   localparam logic [CNT_W-1:0] TERM0_V = CNT_W'(TERM_T0);
   localparam logic [CNT_W-1:0] TERM1_V = CNT_W'(TERM_T1);
   localparam logic [CNT_W-1:0] TERM_RST =
      CNT_W'(bgt_term_for(bgt_proto_e'(RESET_PROTO), TERM_T0, TERM_T1));

   generate
      if (TERM_T0 == TERM_T1) begin : g_fixed
         // Both protocols share one guard time: nothing to remember.
         assign term_o = TERM0_V;
      end else begin : g_latched
         bgt_proto_e proto_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               proto_q <= bgt_proto_e'(RESET_PROTO);
            end else if (start_i) begin
               proto_q <= bgt_proto_e'(proto_i);
            end
         end

         assign term_o = (proto_q == PROTO_T1) ? TERM1_V : TERM0_V;

         a_r8_term_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !start_i |=> $stable(term_o));
      end
   endgenerate

   // R9: the reset protocol fixes the first terminal value
   a_r9_term_reset: assert property (@(posedge clk)
      !rst_n |=> (term_o == TERM_RST) || $past(start_i));
endmodule

// File: rtl/bgt_etu_counter.sv
// Saturating ETU counter: cleared by a start bit, frozen at the terminal.
module bgt_etu_counter #(
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic [CNT_W-1:0] term_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             at_term_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             run;

   assign at_term_o = (cnt_q == term_i);
   assign run       = tick_i && !at_term_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= '0;
      end else if (run) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !start_i && cnt_q < term_i) |=> cnt_q == $past(cnt_q) + 1'b1);
   a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> cnt_q == '0);
   a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && cnt_q == term_i) |=> $stable(cnt_q));
   a_r7_tick_lost: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && tick_i) |=> cnt_q != CNT_W'(1));
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= term_i);
endmodule

// File: rtl/bgt_guard_flag.sv
// Guard-time status flag. REG_FLAG picks a dedicated flop that is set on the
// tick reaching the terminal, or a plain decode of the counter comparison.
module bgt_guard_flag #(
   parameter int unsigned CNT_W    = 5,
   parameter bit          REG_FLAG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             start_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] term_i,
   input  logic             at_term_i,
   output logic             flag_o
);
   generate
      if (REG_FLAG) begin : g_reg
         logic flag_q;
         logic last_step;

         assign last_step = tick_i && !at_term_i && (cnt_i == term_i - 1'b1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flag_q <= 1'b0;
            end else if (start_i) begin
               flag_q <= 1'b0;
            end else if (last_step) begin
               flag_q <= 1'b1;
            end
         end

         assign flag_o = flag_q;
      end else begin : g_decode
         assign flag_o = at_term_i;
      end
   endgenerate

   a_r3_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !flag_o);
   a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !start_i) |=> flag_o);
endmodule

// File: rtl/bgt_etu_monitor.sv
module bgt_etu_monitor
   import bgt_pkg::*;
#(
   parameter int unsigned CNT_W       = 5,
   parameter int unsigned TERM_T0     = 16,
   parameter int unsigned TERM_T1     = 22,
   parameter bit          RESET_PROTO = 1'b0,
   parameter bit          REG_FLAG    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             etu_tick,
   input  logic             start_pulse,
   input  logic             proto_t1,
   output logic             guard_met,
   output logic [CNT_W-1:0] etu_count
);
   localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("bgt_etu_monitor: CNT_W out of range");
      end
      if (TERM_T0 < 1 || TERM_T0 > CNT_MAX) begin : g_bad_t0
         $error("bgt_etu_monitor: TERM_T0 must fit CNT_W and be nonzero");
      end
      if (TERM_T1 < 1 || TERM_T1 > CNT_MAX) begin : g_bad_t1
         $error("bgt_etu_monitor: TERM_T1 must fit CNT_W and be nonzero");
      end
   endgenerate

   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] cnt;
   logic             at_term;

   bgt_term_select #(
      .CNT_W      (CNT_W),
      .TERM_T0    (TERM_T0),
      .TERM_T1    (TERM_T1),
      .RESET_PROTO(RESET_PROTO)
   ) u_term (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_pulse),
      .proto_i(proto_t1),
      .term_o (term)
   );

   bgt_etu_counter #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (etu_tick),
      .start_i  (start_pulse),
      .term_i   (term),
      .cnt_o    (cnt),
      .at_term_o(at_term)
   );

   bgt_guard_flag #(
      .CNT_W   (CNT_W),
      .REG_FLAG(REG_FLAG)
   ) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (etu_tick),
      .start_i  (start_pulse),
      .cnt_i    (cnt),
      .term_i   (term),
      .at_term_i(at_term),
      .flag_o   (guard_met)
   );

   assign etu_count = cnt;

   a_r10_flag_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
      guard_met == (etu_count == term));
   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (etu_count == '0 && !guard_met) || $past(rst_n));
endmodule

// File: tb/bgt_etu_monitor_bench.sv
module bgt_etu_monitor_bench;
   localparam int CNT_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             etu_tick = 1'b0;
   logic             start_pulse = 1'b0;
   logic             proto_t1 = 1'b0;
   logic             guard_met;
   logic [CNT_W-1:0] etu_count;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   // Reference state
   int m_cnt = 0;
   int m_term = 16;
   int m_flag = 0;

   always #4 clk = ~clk;

   bgt_etu_monitor u_bgt_etu_monitor (
      .clk        (clk),
      .rst_n      (rst_n),
      .etu_tick   (etu_tick),
      .start_pulse(start_pulse),
      .proto_t1   (proto_t1),
      .guard_met  (guard_met),
      .etu_count  (etu_count)
   );

   task automatic check_outputs(input string tag);
      checks++;
      if (int'(etu_count) != m_cnt || int'(guard_met) != m_flag) begin
         failures++;
         $display("FAIL %s: count=%0d flag=%0d expected count=%0d flag=%0d",
                  tag, etu_count, guard_met, m_cnt, m_flag);
      end
   endtask

   // Drive one cycle, advance the model at the edge, compare mid-cycle.
   task automatic cyc(input bit t, input bit s, input bit p, input string tag);
      etu_tick    = t;
      start_pulse = s;
      proto_t1    = p;
      @(posedge clk);
      if (s) begin
         m_cnt  = 0;
         m_flag = 0;
         m_term = p ? 22 : 16;
      end else if (t && m_cnt < m_term) begin
         m_cnt++;
         if (m_cnt == m_term) m_flag = 1;
      end
      @(negedge clk);
      check_outputs(tag);
   endtask

   task automatic ticks(input int n, input bit p, input string tag);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, p, tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_outputs("R1 in reset");
      rst_n = 1'b1;
      cyc(1'b0, 1'b0, 1'b0, "R1 after reset");

      // R9: no start yet, select T=1 anyway: terminal stays 16
      ticks(15, 1'b1, "R9 before first start");
      ticks(1, 1'b1, "R9 reach 16");
      ticks(6, 1'b1, "R6 R9 hold at 16");

      // R3 restart from saturation, then R4 under T=0
      cyc(1'b0, 1'b1, 1'b0, "R3 restart");
      for (int i = 0; i < 16; i++) begin
         cyc(1'b1, 1'b0, 1'b0, "R4 T0 count");
         cyc(1'b0, 1'b0, 1'b0, "R2 idle between ticks");
      end
      ticks(5, 1'b0, "R6 saturate T0");

      // R5 under T=1 with select flipped mid-window (R8)
      cyc(1'b0, 1'b1, 1'b1, "R3 start T1");
      ticks(4, 1'b1, "R5 T1 count");
      ticks(20, 1'b0, "R8 select changed mid-window");
      // Reverse: start under T=0, flip to T=1
      cyc(1'b0, 1'b1, 1'b0, "R3 start T0");
      ticks(3, 1'b0, "R4 T0 count");
      ticks(16, 1'b1, "R8 select raised mid-window");

      // R7 coincident start and tick, from mid-count and from terminal
      cyc(1'b1, 1'b1, 1'b0, "R7 start with tick at terminal");
      ticks(7, 1'b0, "R2 counting");
      cyc(1'b1, 1'b1, 1'b1, "R7 start with tick mid-count");
      cyc(1'b1, 1'b1, 1'b1, "R7 back-to-back start with tick");
      ticks(22, 1'b1, "R5 T1 reach 22");
      ticks(3, 1'b0, "R6 hold at 22");

      // Random mix
      for (int i = 0; i < 4000; i++) begin
         bit t = ($urandom % 3) != 0;
         bit s = ($urandom % 40) == 0;
         bit p = ($urandom % 4) == 0 ? ~proto_t1 : proto_t1;
         cyc(t, s, p, "R2 R10 random");
      end

      // R1 reset mid-count
      ticks(3, 1'b0, "R2 counting");
      @(negedge clk);
      rst_n = 1'b0;
      m_cnt = 0; m_flag = 0; m_term = 16;
      #1;
      check_outputs("R1 asynchronous reset");
      @(negedge clk);
      rst_n = 1'b1;
      ticks(16, 1'b1, "R9 after second reset");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule